// File: doc/BRIEF.md
# SPI Flash Command-Menu Sequencer

This block is a register-programmed SPI master that runs one flash command cycle per start request. Software fills a table of eight opcodes, each with a two-bit type code, plus a prefix opcode, a 24-bit flash address and a 64-byte data buffer. It then writes a control word that picks a table entry, sets how many data bytes move, and starts the cycle. The sequencer sends the opcode, the three address bytes when the type has an address, and the data bytes. Read bytes go into the buffer. Sticky status bits report completion or error.

When the control word asks for it, the prefix opcode (typically a write enable) goes out first in its own chip-select frame. The main command follows at once, so no other bus master can get in between. A lock bit makes the opcode table, the type register and the prefix register read-only until reset. The register port is a plain single-cycle write/read port: a write is taken in the cycle `bus_wr` is high, a read returns `bus_rdata` combinationally for `bus_addr`, and the port never stalls, so there is no back-pressure.

Register word addresses: 0 control, 1 status, 2 address, 3 prefix opcode (bits [7:0]), 4 type register (bits [15:0]), 5 table entries 0..3 (entry n in bits [8n+7:8n]), 6 table entries 4..7 (same layout), 16..31 data buffer words 0..15.

Top module: `sfm_seq`

## Requirements
- R1: After reset the status word reads 0, `spi_cs_n` is high and `spi_sclk` is low.
- R2: A started cycle sends the opcode of the selected table entry (control bits [6:4] pick the entry) as the first byte of a chip-select frame. It uses SPI mode 0: the clock idles low, MOSI changes after the falling edge and is sampled on the rising edge, MSB first. The clock toggles only while chip select is low.
- R3: Entry i's type sits in type-register bits [2i+1:2i]: 0 read without address, 1 write without address, 2 read with address, 3 write with address. Types 2 and 3 send address bits [23:16], [15:8] and [7:0] after the opcode, and address-register bits [31:24] are ignored. Types 0 and 1 send no address.
- R4: With data enable set (control bit 14) and a write type, the block sends (control bits [13:8]) + 1 bytes from the buffer, starting at byte 0. Buffer byte 4w+b is bits [8b+7:8b] of buffer word w.
- R5: With data enable set and a read type, the block sends zeros on MOSI and stores the bytes it receives into the buffer from byte 0 upward, with the same byte order within a word, before it sets done.
- R6: With data enable clear, only the opcode and any address bytes are sent.
- R7: With control bit 2 set, the prefix opcode goes out alone in one frame, chip select goes high, and then the main command follows in a second frame.
- R8: Status bit 0 is high while a cycle runs. Done (bit 2) is set when the frame ends and chip select is high again. Done and error (bit 3) stay set until software writes 1 to them.
- R9: A start request (control bit 1) while a cycle runs sets error and leaves the running frame unchanged.
- R10: With data enable set, a start whose direction bit (control bit 0, 1 = read) disagrees with the entry type's write flag (type bit 0) sets error and sends no frame.
- R11: Writing 1 to status bit 15 sets the lock. While locked, writes to the table, the type register and the prefix register are ignored, and nothing but reset clears the lock.
- R12: A count field of 63 moves 64 bytes, and the last read byte lands in buffer word 15, bits [31:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench targets the byte boundaries inside a frame. These are the handoff from opcode to address, from address to data, and the 64-byte limit. A design that miscounts the header would send a stray address byte on a no-address type, or drop the last data byte. It also checks the seam between the prefix frame and the main frame: merging them into one frame shows up as a wrong frame length. It starts a cycle on top of a running one and starts one with the wrong direction. A design that obeyed either request would send an extra or corrupted frame instead of only raising error. Finally it writes the table after locking, and a design that let that through would send the new opcode.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_GAP, ST_MAIN} seq_st_t;

  localparam int RA_CTRL   = 0;
  localparam int RA_STAT   = 1;
  localparam int RA_ADDR   = 2;
  localparam int RA_PREF   = 3;
  localparam int RA_TYPES  = 4;
  localparam int RA_MENULO = 5;
  localparam int RA_MENUHI = 6;

  localparam int MENU_N = 8;

  // control word fields
  localparam int C_DIR  = 0;
  localparam int C_GO   = 1;
  localparam int C_ATOM = 2;
  localparam int C_DEN  = 14;
  // status word fields
  localparam int S_BUSY = 0;
  localparam int S_DONE = 2;
  localparam int S_ERR  = 3;
  localparam int S_LOCK = 15;
endpackage

// File: rtl/sfm_shift.sv
module sfm_shift #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    sh, rxs;
  logic          act, sclk_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0; bitn <= '0; sh <= '0; rxs <= '0;
      act <= 1'b0; sclk_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !act) begin
        act    <= 1'b1;
        sh     <= tx;
        bitn   <= '0;
        div    <= '0;
        sclk_q <= 1'b0;
      end else if (act) begin
        if (div == DW'(HALF - 1)) begin
          div <= '0;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rxs    <= {rxs[6:0], miso};
          end else begin
            sclk_q <= 1'b0;
            sh     <= {sh[6:0], 1'b0};
            bitn   <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              act    <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          div <= div + DW'(1);
        end
      end
    end
  end

  assign sclk = sclk_q;
  assign mosi = sh[7];
  assign done = done_q;
  assign rx   = rxs;

  // R2: the clock only runs while a byte is being shifted
  p_sclk_needs_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> act);
  // R2: MOSI is settled before each rising clock edge
  p_mosi_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(mosi));
endmodule

// File: rtl/sfm_buf.sv
module sfm_buf #(
  parameter int BYTES = 64
) (
  input  logic                       clk,
  input  logic                       bus_we,
  input  logic [$clog2(BYTES/4)-1:0] bus_widx,
  input  logic [31:0]                bus_wdata,
  input  logic [$clog2(BYTES/4)-1:0] bus_ridx,
  output logic [31:0]                bus_rdata,
  input  logic                       seq_we,
  input  logic [$clog2(BYTES)-1:0]   seq_idx,
  input  logic [7:0]                 seq_wbyte,
  output logic [7:0]                 seq_rbyte
);
  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (bus_we) begin
      for (int b = 0; b < 4; b++) mem[{bus_widx, 2'(b)}] <= bus_wdata[8*b +: 8];
    end
    if (seq_we) mem[seq_idx] <= seq_wbyte;
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign bus_rdata[8*g +: 8] = mem[{bus_ridx, 2'(g)}];
  end
  assign seq_rbyte = mem[seq_idx];
endmodule

// File: rtl/sfm_seq.sv
module sfm_seq
  import sfm_pkg::*;
#(
  parameter int SCK_HALF  = 2,
  parameter int BUF_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [$clog2(BUF_BYTES/4):0]  bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic                          spi_sclk,
  output logic                          spi_cs_n,
  output logic                          spi_mosi,
  input  logic                          spi_miso
);
  localparam int WI = $clog2(BUF_BYTES / 4);
  localparam int BI = $clog2(BUF_BYTES);
  localparam int AW = WI + 1;
  localparam int KW = $clog2(BUF_BYTES + 4) + 1;

  seq_st_t       st;
  logic [7:0]    menu [MENU_N];
  logic [15:0]   types;
  logic [7:0]    pref;
  logic [31:0]   addr;
  logic          lock, done, err, kick;
  logic [7:0]    op;
  logic [1:0]    typ;
  logic [BI-1:0] cnt;
  logic          den;
  logic [KW-1:0] k;

  logic          sh_done, busy, is_buf, wr_ctrl, go, bad_dir;
  logic [7:0]    sh_rx, sh_tx, main_tx, b_rbyte;
  logic [31:0]   b_rword;
  logic [KW-1:0] hdr, total;
  logic [BI-1:0] didx;
  logic          b_swe;
  logic [2:0]    sel;

  assign busy    = (st != ST_IDLE);
  assign is_buf  = bus_addr[AW-1];
  assign wr_ctrl = bus_wr && !is_buf && (bus_addr == AW'(RA_CTRL));
  assign go      = wr_ctrl && bus_wdata[C_GO];
  assign sel     = bus_wdata[6:4];
  assign bad_dir = bus_wdata[C_DEN] && (types[{sel, 1'b0}] == bus_wdata[C_DIR]);

  assign hdr   = typ[1] ? KW'(4) : KW'(1);
  assign total = hdr + (den ? (KW'(cnt) + KW'(1)) : KW'(0));
  assign didx  = BI'(k - hdr);

  always_comb begin
    if (k == '0)                    main_tx = op;
    else if (typ[1] && k == KW'(1)) main_tx = addr[23:16];
    else if (typ[1] && k == KW'(2)) main_tx = addr[15:8];
    else if (typ[1] && k == KW'(3)) main_tx = addr[7:0];
    else if (typ[0])                main_tx = b_rbyte;
    else                            main_tx = 8'h00;
  end
  assign sh_tx = (st == ST_PRE) ? pref : main_tx;
  assign b_swe = sh_done && (st == ST_MAIN) && (k >= hdr) && !typ[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; types <= '0; pref <= '0; addr <= '0;
      lock <= 1'b0; done <= 1'b0; err <= 1'b0; kick <= 1'b0;
      op <= '0; typ <= '0; cnt <= '0; den <= 1'b0; k <= '0;
      for (int i = 0; i < MENU_N; i++) menu[i] <= '0;
    end else begin
      kick <= 1'b0;
      if (bus_wr && !is_buf) begin
        unique case (int'(bus_addr))
          RA_STAT: begin
            if (bus_wdata[S_DONE]) done <= 1'b0;
            if (bus_wdata[S_ERR])  err  <= 1'b0;
            if (bus_wdata[S_LOCK]) lock <= 1'b1;
          end
          RA_ADDR:   addr <= bus_wdata;
          RA_PREF:   if (!lock) pref  <= bus_wdata[7:0];
          RA_TYPES:  if (!lock) types <= bus_wdata[15:0];
          RA_MENULO: if (!lock) for (int b = 0; b < 4; b++) menu[b]   <= bus_wdata[8*b +: 8];
          RA_MENUHI: if (!lock) for (int b = 0; b < 4; b++) menu[b+4] <= bus_wdata[8*b +: 8];
          default: ;
        endcase
      end
      if (go) begin
        if (busy || bad_dir) begin
          err <= 1'b1;
        end else begin
          op   <= menu[sel];
          typ  <= types[{sel, 1'b0} +: 2];
          cnt  <= bus_wdata[8 +: BI];
          den  <= bus_wdata[C_DEN];
          k    <= '0;
          kick <= 1'b1;
          st   <= bus_wdata[C_ATOM] ? ST_PRE : ST_MAIN;
        end
      end
      unique case (st)
        ST_PRE:  if (sh_done) st <= ST_GAP;
        ST_GAP:  begin st <= ST_MAIN; k <= '0; kick <= 1'b1; end
        ST_MAIN: if (sh_done) begin
          if (k == total - KW'(1)) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            k    <= k + KW'(1);
            kick <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign spi_cs_n = !((st == ST_PRE) || (st == ST_MAIN));

  always_comb begin
    bus_rdata = '0;
    if (is_buf) bus_rdata = b_rword;
    else begin
      unique case (int'(bus_addr))
        RA_STAT:   begin
          bus_rdata[S_BUSY] = busy;
          bus_rdata[S_DONE] = done;
          bus_rdata[S_ERR]  = err;
          bus_rdata[S_LOCK] = lock;
        end
        RA_ADDR:   bus_rdata = addr;
        RA_PREF:   bus_rdata = {24'h0, pref};
        RA_TYPES:  bus_rdata = {16'h0, types};
        RA_MENULO: bus_rdata = {menu[3], menu[2], menu[1], menu[0]};
        RA_MENUHI: bus_rdata = {menu[7], menu[6], menu[5], menu[4]};
        default:   bus_rdata = '0;
      endcase
    end
  end

  sfm_shift #(.HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(kick), .tx(sh_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx)
  );

  sfm_buf #(.BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .bus_we(bus_wr && is_buf), .bus_widx(bus_addr[WI-1:0]),
    .bus_wdata(bus_wdata), .bus_ridx(bus_addr[WI-1:0]), .bus_rdata(b_rword),
    .seq_we(b_swe), .seq_idx(didx), .seq_wbyte(sh_rx), .seq_rbyte(b_rbyte)
  );

  // R2: serial clock only inside a chip-select frame
  p_sclk_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);
  // R8: done appears only with the chip select released
  p_done_after_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> spi_cs_n);
  // R9: start on top of a running cycle raises error
  p_busy_go_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && busy) |=> err);
  // R11: lock never drops and freezes the command setup
  p_lock_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  p_lock_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> ($stable(types) && $stable(pref)));
endmodule

// File: tb/sfm_seq_bench.sv
module sfm_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0;
  int errors = 0;
  bit fin = 1'b0;

  byte unsigned exp_q[$];
  int           frm_q[$];
  int           frames_seen = 0;

  always #10 clk = ~clk;

  sfm_seq u_sfm_seq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] pat(int i);
    return 8'h5A ^ 8'(i * 37);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flash model and scoreboard monitor, all at the falling clock edge
  logic       prev_sclk = 1'b0, prev_cs = 1'b1;
  logic [7:0] shreg = '0;
  int nbits = 0, fbytes = 0, mpos = 0, mbyte = 0;
  assign spi_miso = pat(mbyte)[7 - mpos];

  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_cs_n) begin
        if (!prev_cs) begin
          frames_seen++;
          if (frm_q.size() == 0) chk("R2 unexpected frame", fbytes, 0);
          else chk("R7 frame length", fbytes, frm_q.pop_front());
        end
        nbits = 0; fbytes = 0; mpos = 0; mbyte = 0;
      end else begin
        if (spi_sclk && !prev_sclk) begin
          shreg = {shreg[6:0], spi_mosi};
          nbits++;
          if (nbits == 8) begin
            nbits = 0;
            fbytes++;
            if (exp_q.size() == 0) chk("R2 unexpected byte", shreg, 0);
            else chk("R2/R3/R4 mosi byte", shreg, exp_q.pop_front());
          end
        end
        if (!spi_sclk && prev_sclk) begin
          if (mpos == 7) begin mpos = 0; mbyte++; end
          else mpos++;
        end
      end
      prev_sclk = spi_sclk;
      prev_cs   = spi_cs_n;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl(int idx, int cnt, bit den, bit atom, bit dir);
    return (32'(den) << 14) | (32'(cnt) << 8) | (32'(idx) << 4) |
           (32'(atom) << 2) | 32'h2 | 32'(dir);
  endfunction

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(1, s);
      if (!s[0]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic push(logic [7:0] b);
    exp_q.push_back(b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int f0;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(1, r); chk("R1 status", r, 0);
    chk("R1 cs_n", 32'(spi_cs_n), 1);
    chk("R1 sclk", 32'(spi_sclk), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    wr(5, 32'h02030506);
    wr(6, 32'hC79FD80B);
    wr(4, 32'h00004EE1);
    wr(3, 32'h00000006);
    rd(5, r); chk("R2 table readback", r, 32'h02030506);

    // R4: write with address, 4 data bytes
    wr(16, 32'h44332211);
    wr(2, 32'h00123456);
    push(8'h02); push(8'h12); push(8'h34); push(8'h56);
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    frm_q.push_back(8);
    wr(0, ctl(3, 3, 1, 0, 0));
    rd(1, r); chk("R8 busy while running", r[0], 1);
    wait_idle();
    rd(1, r); chk("R8 done set", r & 32'hD, 32'h4);
    wr(1, 32'h4);
    rd(1, r); chk("R8 done cleared", r, 0);

    // R5: read with address, 8 bytes
    push(8'h03); push(8'h12); push(8'h34); push(8'h56);
    for (int j = 0; j < 8; j++) push(8'h00);
    frm_q.push_back(12);
    wr(0, ctl(2, 7, 1, 0, 1));
    wait_idle();
    rd(16, r); chk("R5 read word0", r, {pat(7), pat(6), pat(5), pat(4)});
    rd(17, r); chk("R5 read word1", r, {pat(11), pat(10), pat(9), pat(8)});

    // R3: read without address, one byte lands in byte 0
    push(8'h05); push(8'h00); frm_q.push_back(2);
    wr(0, ctl(1, 0, 1, 0, 1));
    wait_idle();
    rd(16, r); chk("R3 no-address read byte0", r[7:0], pat(1));

    // R6: data enable clear
    push(8'h06); frm_q.push_back(1);
    wr(0, ctl(0, 5, 0, 0, 0));
    wait_idle();
    push(8'h03); push(8'h12); push(8'h34); push(8'h56); frm_q.push_back(4);
    wr(0, ctl(2, 5, 0, 0, 0));
    wait_idle();

    // R7: atomic prefix frame then main frame
    wr(16, 32'h44332211);
    wr(2, 32'h0000ABCD);
    push(8'h06); frm_q.push_back(1);
    push(8'h02); push(8'h00); push(8'hAB); push(8'hCD); push(8'h11); push(8'h22);
    frm_q.push_back(6);
    f0 = frames_seen;
    wr(0, ctl(3, 1, 1, 1, 0));
    wait_idle();
    chk("R7 two frames", frames_seen - f0, 2);

    // R9: start while busy
    wr(1, 32'hC);
    push(8'h02); push(8'h00); push(8'hAB); push(8'hCD);
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    frm_q.push_back(8);
    f0 = frames_seen;
    wr(0, ctl(3, 3, 1, 0, 0));
    repeat (20) @(negedge clk);
    wr(0, ctl(0, 0, 0, 0, 0));
    wait_idle();
    rd(1, r); chk("R9 error and done", r & 32'hD, 32'hC);
    chk("R9 single frame", frames_seen - f0, 1);
    wr(1, 32'hC);
    rd(1, r); chk("R8 both cleared", r, 0);

    // R10: direction mismatch
    f0 = frames_seen;
    wr(0, ctl(3, 3, 1, 0, 1));
    repeat (40) @(negedge clk);
    rd(1, r); chk("R10 error no busy", r & 32'hD, 32'h8);
    chk("R10 no frame", frames_seen - f0, 0);
    wr(1, 32'h8);

    // R11: lock
    wr(1, 32'h8000);
    wr(5, 32'hAAAAAAAA);
    wr(3, 32'h000000FF);
    rd(5, r); chk("R11 table frozen", r, 32'h02030506);
    rd(3, r); chk("R11 prefix frozen", r, 32'h06);
    wr(1, 32'h0000000C);
    rd(1, r); chk("R11 lock kept", r[15], 1);
    push(8'h06); frm_q.push_back(1);
    wr(0, ctl(0, 0, 0, 0, 0));
    wait_idle();

    // R12: 64-byte read, upper address bits ignored (R3)
    wr(2, 32'hABFEDCBA);
    push(8'h0B); push(8'hFE); push(8'hDC); push(8'hBA);
    for (int j = 0; j < 64; j++) push(8'h00);
    frm_q.push_back(68);
    wr(0, ctl(4, 63, 1, 0, 1));
    wait_idle();
    rd(16, r); chk("R12 first word", r, {pat(7), pat(6), pat(5), pat(4)});
    rd(31, r); chk("R12 last word", r, {pat(67), pat(66), pat(65), pat(64)});

    chk("R2 expected bytes drained", exp_q.size(), 0);
    chk("R7 expected frames drained", frm_q.size(), 0);
    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule